// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning and Reset Request

This block is a watchdog that sits on a simple register port. Once software sets the run bit, a 32-bit count advances by one on every clock tick. Two thresholds, both held in ticks, are compared against the count. The lower one, the warning threshold, raises a level interrupt if its enable bit is set. The upper one, the expiry threshold, sends a one-cycle reset request to the system reset controller. Software keeps the system alive by writing 1 to the restart register, which sets the count back to zero. A status bit records that an expiry has happened. Only the power-on reset clears it, so it is still set after the reset that the expiry causes.

A state machine sequences the count through four states:
- `ST_OFF`: idle, count held at zero.
- `ST_RUN`: counting, warning not yet reached.
- `ST_BARK`: counting, warning reached.
- `ST_EXPIRED`: count frozen at the expiry threshold.

It has these transitions:
- start: `ST_OFF` to `ST_RUN`, on the first clock with the run bit set.
- warn: `ST_RUN` to `ST_BARK`, when the count equals the warning threshold.
- expire: `ST_RUN` or `ST_BARK` to `ST_EXPIRED`, when the count equals the expiry threshold. This transition also sets the warning flag if the two thresholds are equal.
- kick: any state to `ST_RUN` with the count at zero, on a restart write while running.
- stop: any state to `ST_OFF`, while the run bit is clear. Stop takes priority over kick.

The parameter `ALT_MAP` selects between two register layouts at build time.

Top module: `wdt_bark_bite`

## Requirements
- R1: With `ALT_MAP=0` the registers are at these offsets: restart 0x04, control 0x08, status 0x0C, warning threshold 0x10, expiry threshold 0x14. Control and both thresholds read back the last value written. The restart register reads 0.
- R2: With `ALT_MAP=1` the same registers are at these offsets: restart 0x38, control 0x40, status 0x44, warning threshold 0x4C, expiry threshold 0x5C.
- R3: Control bit 0 is run and bit 1 is interrupt enable. When run is cleared, counting stops, the count returns to zero and `irq_bark` falls. No `rst_req` follows.
- R4: A write to restart with wdata bit 0 = 1 while running zeroes the count in the write cycle, so expiry comes threshold+1 cycles after that write edge. The same write also clears `irq_bark`. A restart write with bit 0 = 0 has no effect.
- R5: After the edge that writes run = 1, `rst_req` is high for exactly one cycle, sampled after edge expiry+2. It does not pulse again while the watchdog stays expired.
- R6: With interrupt enable set and warning ≤ expiry, `irq_bark` rises after edge warning+2 from the run write and stays high until a restart or stop. With interrupt enable clear, or with warning > expiry, it never rises.
- R7: With equal thresholds, `irq_bark` (if enabled) and `rst_req` assert in the same cycle.
- R8: Status bit 0 reads 1 after any expiry. Neither stop nor restart clears it; only `por_n` does.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R10: Thresholds are 32 bits, so 0x10000000 and 0xFFFFFFFF read back intact. The count stops at the expiry threshold and does not wrap.
- R11: After power-on reset, every register reads 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; the count advances once per rising edge |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | ADDR_W | Byte offset for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| irq_bark | output | 1 | Level early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds two copies of the block on one shared bus: one with `ALT_MAP=0` and one with `ALT_MAP=1`. Because they share the bus, every write aimed at one layout lands on an unmapped offset of the other. This tests the ignore-and-read-zero rule in both directions without any extra stimulus. Both copies use the default 32-bit width, so full-range thresholds can be read back. Short threshold values in the vector table reach the expiry, equal-threshold, zero-threshold and inverted-threshold cases within a few dozen cycles each.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_BARK,
        ST_EXPIRED
    } wdt_state_e;

    typedef struct packed {
        logic irq_en;
        logic run;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status_bit,
    output logic [DATA_W-1:0] rdata,
    output wdt_ctrl_t         ctrl,
    output logic [DATA_W-1:0] warn_thr,
    output logic [DATA_W-1:0] expiry_thr,
    output logic              kick
);

    localparam int OFS_KICK_I   = ALT_MAP ? 32'h38 : 32'h04;
    localparam int OFS_CTRL_I   = ALT_MAP ? 32'h40 : 32'h08;
    localparam int OFS_STAT_I   = ALT_MAP ? 32'h44 : 32'h0C;
    localparam int OFS_WARN_I   = ALT_MAP ? 32'h4C : 32'h10;
    localparam int OFS_EXPIRY_I = ALT_MAP ? 32'h5C : 32'h14;

    localparam logic [ADDR_W-1:0] OFS_KICK   = OFS_KICK_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OFS_CTRL   = OFS_CTRL_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OFS_STAT   = OFS_STAT_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OFS_WARN   = OFS_WARN_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] OFS_EXPIRY = OFS_EXPIRY_I[ADDR_W-1:0];

    logic sel_kick, sel_ctrl, sel_stat, sel_warn, sel_expiry, sel_any;

    wdt_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] warn_q;
    logic [DATA_W-1:0] expiry_q;

    always_comb begin
        sel_kick   = (addr == OFS_KICK);
        sel_ctrl   = (addr == OFS_CTRL);
        sel_stat   = (addr == OFS_STAT);
        sel_warn   = (addr == OFS_WARN);
        sel_expiry = (addr == OFS_EXPIRY);
        sel_any    = sel_kick | sel_ctrl | sel_stat | sel_warn | sel_expiry;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_q   <= '0;
            warn_q   <= '0;
            expiry_q <= '0;
        end else if (wr_en) begin
            if (sel_ctrl)   ctrl_q   <= wdt_ctrl_t'(wdata[CTRL_W-1:0]);
            if (sel_warn)   warn_q   <= wdata;
            if (sel_expiry) expiry_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl)   rdata[CTRL_W-1:0] = ctrl_q;
        if (sel_stat)   rdata[0]          = status_bit;
        if (sel_warn)   rdata             = warn_q;
        if (sel_expiry) rdata             = expiry_q;
    end

    assign ctrl       = ctrl_q;
    assign warn_thr   = warn_q;
    assign expiry_thr = expiry_q;
    assign kick       = wr_en & sel_kick & wdata[0];

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !sel_any) |=> ($stable(ctrl_q) && $stable(warn_q) && $stable(expiry_q)));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             kick,
    input  logic [CNT_W-1:0] warn_thr,
    input  logic [CNT_W-1:0] expiry_thr,
    output logic             warn_hit,
    output logic             rst_req,
    output logic             expired_flag
);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             warn_set, expiry_fire;
    logic             warn_q, rst_q, flag_q;

    // next-state and count
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        warn_set    = 1'b0;
        expiry_fire = 1'b0;
        if (!run) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else if (kick) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
                ST_RUN, ST_BARK: begin
                    if (cnt_q == expiry_thr) begin
                        state_d     = ST_EXPIRED;
                        expiry_fire = 1'b1;
                        warn_set    = (cnt_q == warn_thr);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == warn_thr) begin
                            warn_set = 1'b1;
                            state_d  = ST_BARK;
                        end
                    end
                end
                ST_EXPIRED: begin
                    state_d = ST_EXPIRED;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            warn_q <= 1'b0;
            rst_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            rst_q  <= expiry_fire;
            flag_q <= flag_q | expiry_fire;
            if (!run || kick) warn_q <= 1'b0;
            else if (warn_set) warn_q <= 1'b1;
        end
    end

    assign warn_hit     = warn_q;
    assign rst_req      = rst_q;
    assign expired_flag = flag_q;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!por_n)
        rst_q |=> !rst_q);

    assert_pulse_from_expiry_R5: assert property (@(posedge clk) disable iff (!por_n)
        rst_q |-> (state_q == ST_EXPIRED));

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        flag_q |=> flag_q);

    assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> (cnt_q == '0 && !warn_q && state_q == ST_OFF));

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
        (run && kick) |=> (cnt_q == '0 && !warn_q));

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_EXPIRED && run && !kick) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite
    import wdt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_bark,
    output logic              rst_req
);

    wdt_ctrl_t         ctrl;
    logic [DATA_W-1:0] warn_thr, expiry_thr;
    logic              kick, warn_hit, expired_flag;

    wdt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ALT_MAP(ALT_MAP)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .status_bit(expired_flag),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .warn_thr  (warn_thr),
        .expiry_thr(expiry_thr),
        .kick      (kick)
    );

    wdt_core #(
        .CNT_W(DATA_W)
    ) u_core (
        .clk         (clk),
        .por_n       (por_n),
        .run         (ctrl.run),
        .kick        (kick),
        .warn_thr    (warn_thr),
        .expiry_thr  (expiry_thr),
        .warn_hit    (warn_hit),
        .rst_req     (rst_req),
        .expired_flag(expired_flag)
    );

    assign irq_bark = warn_hit & ctrl.irq_en;

    assert_irq_drop_on_stop_R3: assert property (@(posedge clk) disable iff (!por_n)
        (!ctrl.run) |=> !irq_bark);

endmodule

// File: tb/wdt_bark_bite_tb.sv
`timescale 1ns/1ps
module wdt_bark_bite_tb;

    logic        clk = 1'b0;
    logic        por_n;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata, rdata_alt;
    logic        irq_bark, rst_req, irq_alt, rst_alt;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int wcyc = 0;
    int rst_cnt = 0, rst_cyc = 0, irq_cyc = -1, irq_rises = 0;
    int alt_rst_cnt = 0;
    logic irq_prev = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_bark_bite #(.ALT_MAP(1'b0)) u_dut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_bark(irq_bark), .rst_req(rst_req));

    wdt_bark_bite #(.ALT_MAP(1'b1)) u_dut_alt (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_alt), .irq_bark(irq_alt), .rst_req(rst_alt));

    always @(negedge clk) begin
        if (rst_req) begin rst_cnt++; rst_cyc = cyc; end
        if (irq_bark && !irq_prev) begin irq_rises++; irq_cyc = cyc; end
        irq_prev = irq_bark;
        if (rst_alt) alt_rst_cnt++;
    end

    // bark[16:9], bite[8:1], irq enable[0]
    localparam logic [16:0] VECS [0:5] = '{
        {8'd3, 8'd6, 1'b1},
        {8'd5, 8'd5, 1'b1},
        {8'd4, 8'd9, 1'b0},
        {8'd0, 8'd2, 1'b1},
        {8'd7, 8'd3, 1'b1},
        {8'd0, 8'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        wcyc = cyc + 1;
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_alt);
        @(negedge clk);
        addr = a;
        #1 d = rdata; d_alt = rdata_alt;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        total++; fails++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v, va;
        int base, ibase, e, w;
        por_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        idle(3);
        @(negedge clk) por_n = 1'b1;

        // R11 reset state
        rd(8'h08, v, va); chk("R11 ctrl", v, 0);
        rd(8'h0C, v, va); chk("R11 status", v, 0);
        rd(8'h14, v, va); chk("R11 expiry", v, 0);
        chk("R11 outputs", {30'b0, irq_bark, rst_req}, 0);

        // R1 / R10 register access
        wr(8'h10, 32'hFFFFFFFF); rd(8'h10, v, va); chk("R10 warn max", v, 32'hFFFFFFFF);
        wr(8'h14, 32'h10000000); rd(8'h14, v, va); chk("R10 expiry big", v, 32'h10000000);
        wr(8'h08, 32'h2);        rd(8'h08, v, va); chk("R1 ctrl readback", v, 32'h2);
        rd(8'h04, v, va); chk("R1 restart reads zero", v, 0);

        // R9 unmapped writes ignored, reads zero
        wr(8'h18, 32'h55); wr(8'h00, 32'h3);
        rd(8'h18, v, va); chk("R9 unmapped read", v, 0);
        rd(8'h08, v, va); chk("R9 ctrl unchanged", v, 32'h2);
        rd(8'h14, v, va); chk("R9 expiry unchanged", v, 32'h10000000);
        wr(8'h08, 32'h0);

        // Vector table: R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            int bark, bite, ie;
            bark = int'(VECS[i][16:9]); bite = int'(VECS[i][8:1]); ie = int'(VECS[i][0]);
            wr(8'h08, 32'h0);
            wr(8'h10, bark); wr(8'h14, bite);
            base = rst_cnt; ibase = irq_rises;
            wr(8'h08, {30'b0, ie[0], 1'b1});
            e = wcyc;
            idle(bite + 8);
            chk("R5 one pulse", rst_cnt - base, 1);
            chk("R5 pulse cycle", rst_cyc - e, bite + 2);
            if (ie == 1 && bark <= bite) begin
                chk("R6 irq rose", irq_rises - ibase, 1);
                chk("R6 irq cycle", irq_cyc - e, bark + 2);
                chk("R6 irq level held", irq_bark, 1);
                if (bark == bite) chk("R7 same cycle", irq_cyc, rst_cyc);
            end else begin
                chk("R6 irq absent", irq_rises - ibase, 0);
            end
            rd(8'h0C, v, va); chk("R8 status set", v, 1);
        end

        // R3 stop drops irq and counting
        wr(8'h08, 32'h0); wr(8'h10, 2); wr(8'h14, 30);
        wr(8'h08, 32'h3); idle(8);
        chk("R3 irq before stop", irq_bark, 1);
        base = rst_cnt;
        wr(8'h08, 32'h0);
        @(negedge clk); chk("R3 irq after stop", irq_bark, 0);
        idle(40); chk("R3 no expiry when stopped", rst_cnt - base, 0);
        rd(8'h0C, v, va); chk("R8 status survives stop", v, 1);

        // R4 restart
        wr(8'h10, 10); wr(8'h14, 20);
        base = rst_cnt; ibase = irq_rises;
        wr(8'h08, 32'h3); idle(8);
        wr(8'h04, 32'h1); w = wcyc;
        idle(14);
        chk("R4 irq after kick", irq_cyc - w, 11);
        wr(8'h04, 32'h1); w = wcyc;
        @(negedge clk); chk("R4 kick clears irq", irq_bark, 0);
        idle(25);
        chk("R4 one expiry", rst_cnt - base, 1);
        chk("R4 expiry after kick", rst_cyc - w, 21);
        wr(8'h08, 32'h0);
        base = rst_cnt;
        wr(8'h08, 32'h1); e = wcyc;
        idle(5); wr(8'h04, 32'h0);
        idle(25);
        chk("R4 kick bit0 zero ignored", rst_cyc - e, 22);
        chk("R4 single pulse", rst_cnt - base, 1);
        rd(8'h0C, v, va); chk("R8 status survives kick", v, 1);
        wr(8'h08, 32'h0);

        // R2 alternate map
        wr(8'h4C, 32'h123);
        rd(8'h4C, v, va);
        chk("R2 alt warn readback", va, 32'h123);
        chk("R9 primary ignores alt offset", v, 0);
        rd(8'h44, v, va); chk("R2 alt status clear", va, 0);
        wr(8'h5C, 3);
        base = alt_rst_cnt;
        wr(8'h40, 32'h1); idle(10);
        chk("R2 alt expiry", alt_rst_cnt - base, 1);
        rd(8'h44, v, va); chk("R2 alt status set", va, 1);
        rd(8'h40, v, va); chk("R2 alt ctrl readback", va, 1);
        chk("R9 primary ctrl untouched", v, 0);

        // R8 / R11 power-on reset clears status
        @(negedge clk) por_n = 1'b0;
        idle(2);
        @(negedge clk) por_n = 1'b1;
        rd(8'h0C, v, va); chk("R8 status cleared by por", v, 0);
        chk("R11 alt status cleared", va, 0);
        rd(8'h10, v, va); chk("R11 warn cleared", v, 0);

        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule